// File: doc/BRIEF.md
# Shared Data and Stack Byte Memory

This block is a 256-byte memory that serves two users. Ordinary data is placed from the bottom of the address space and grows upward. A stack starts at the top address and grows downward. The stack pointer is kept inside the block. A caller issues one operation at a time by raising `start_i` with an operation code. The operations are a byte load and a byte store at base plus offset, a push of a value taken from the write-data input, a push of a byte copied from memory at base plus offset, and a pop.

Most operations complete at the clock edge that accepts them, and `done_o` pulses in the following cycle. The memory-to-memory push needs two steps. It reads the source byte first, then writes that byte to the top of the stack one cycle later. `busy_o` covers the gap between the two steps. A push that takes the pointer past the bottom address is flagged but still carried out. A pop from an empty stack is flagged and has no effect.

Top module: `shared_stack_mem`

## Requirements
- R1: After reset the stack pointer output is 0xFF and busy, done, overflow and underflow are all low.
- R2: Operation codes: 0 idle, 1 load, 2 store, 3 push input byte, 4 push memory byte, 5 pop. A store (2) writes the write-data byte at (base + offset) mod 256. A load (1) returns the byte at (base + offset) mod 256 on the read-data output in the cycle after acceptance, with done high in that cycle.
- R3: Loads and stores never change the stack pointer.
- R4: A push of the input byte (3) writes it at the current stack pointer address and then lowers the pointer by one. Done is high in the next cycle.
- R5: A push issued while the pointer is 0x00 still writes address 0x00. The pointer wraps to 0xFF, and the overflow output is high for exactly the one cycle in which done is high.
- R6: A push of a memory byte (4) raises busy for one cycle with done low. In the following cycle done is high, busy is low, the byte from (base + offset) mod 256 is stored at the old pointer address, and the pointer has dropped by one. Start requests made while busy is high are ignored.
- R7: A pop (5) first raises the pointer by one, then returns the byte at the new pointer address on read data in the cycle after acceptance. Pops return pushed bytes in reverse order.
- R8: A pop while the pointer is 0xFF leaves the pointer at 0xFF, returns 0x00 on read data, and raises underflow together with done for one cycle.
- R9: With start low, or with operation code 0, 6 or 7, no memory byte and no pointer value changes, and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to perform op_i; ignored while busy_o is high |
| op_i | input | 3 | Operation code (see R2) |
| base_i | input | 8 | Base address for load, store and memory push |
| offset_i | input | 8 | Offset added to base_i, modulo 256 |
| wdata_i | input | 8 | Byte for store and for the input-byte push |
| rdata_o | output | 8 | Byte returned by load or pop |
| busy_o | output | 1 | High while the second step of a memory push is pending |
| done_o | output | 1 | One-cycle pulse when an operation finishes |
| sp_o | output | 8 | Current stack pointer |
| ovf_o | output | 1 | Pulse: a push wrapped the pointer below 0x00 |
| udf_o | output | 1 | Pulse: a pop was requested on an empty stack |

## Verification
Loads and stores are tried with base/offset pairs whose sum overflows 8 bits and with pairs whose sum does not. This separates a true modulo-256 adder from one that drops the carry into the wrong place or ignores the offset. Push and pop sequences with distinct bytes show whether the pointer moves before or after the memory access, since an off-by-one order returns the wrong byte or a neighbour. A memory push from a prepared source byte, with a competing request placed in its busy cycle, shows both the two-step copy and the blocking of new requests. Filling the stack until the pointer wraps, and popping an empty stack, exercise the two flags and the no-effect rule.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_LOAD    = 3'd1,
        OP_STORE   = 3'd2,
        OP_PUSH_IN = 3'd3,
        OP_PUSH_MM = 3'd4,
        OP_POP     = 3'd5
    } ssm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_COPY = 1'b1
    } ssm_state_e;

    typedef struct packed {
        ssm_state_e        state;
        logic [ADDR_W-1:0] sp;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] hold;
        logic              busy;
        logic              done;
        logic              ovf;
        logic              udf;
    } ssm_regs_t;
endpackage

// File: rtl/ssm_ram.sv
module ssm_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/ssm_agen.sv
module ssm_agen #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] offset_i,
    input  logic [AW-1:0] sp_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] sp_up_o,
    output logic [AW-1:0] sp_dn_o,
    output logic          sp_top_o,
    output logic          sp_bot_o
);
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] BOT = '0;

    always_comb begin
        ea_o     = base_i + offset_i;
        sp_up_o  = sp_i + 1'b1;
        sp_dn_o  = sp_i - 1'b1;
        sp_top_o = (sp_i == TOP);
        sp_bot_o = (sp_i == BOT);
    end
endmodule

// File: rtl/shared_stack_mem.sv
module shared_stack_mem
    import ssm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] offset_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] sp_o,
    output logic          ovf_o,
    output logic          udf_o
);
    localparam logic [AW-1:0] SP_INIT = '1;

    ssm_regs_t r_q, r_d;

    logic [AW-1:0] ea, sp_up, sp_dn;
    logic          sp_top, sp_bot;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    ssm_op_e       op;

    assign op = ssm_op_e'(op_i);

    ssm_agen #(.AW(AW)) u_agen (
        .base_i   (base_i),
        .offset_i (offset_i),
        .sp_i     (r_q.sp),
        .ea_o     (ea),
        .sp_up_o  (sp_up),
        .sp_dn_o  (sp_dn),
        .sp_top_o (sp_top),
        .sp_bot_o (sp_bot)
    );

    ssm_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.ovf   = 1'b0;
        r_d.udf   = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = r_q.sp;
        mem_wdata = wdata_i;
        mem_raddr = ea;

        if (r_q.state == ST_COPY) begin
            // second step of memory push: write held byte at top of stack
            mem_we    = 1'b1;
            mem_waddr = r_q.sp;
            mem_wdata = r_q.hold;
            r_d.sp    = sp_dn;
            r_d.ovf   = sp_bot;
            r_d.done  = 1'b1;
            r_d.busy  = 1'b0;
            r_d.state = ST_IDLE;
        end else if (start_i) begin
            unique case (op)
                OP_LOAD: begin
                    mem_raddr = ea;
                    r_d.rdata = mem_rdata;
                    r_d.done  = 1'b1;
                end
                OP_STORE: begin
                    mem_we    = 1'b1;
                    mem_waddr = ea;
                    mem_wdata = wdata_i;
                    r_d.done  = 1'b1;
                end
                OP_PUSH_IN: begin
                    mem_we    = 1'b1;
                    mem_waddr = r_q.sp;
                    mem_wdata = wdata_i;
                    r_d.sp    = sp_dn;
                    r_d.ovf   = sp_bot;
                    r_d.done  = 1'b1;
                end
                OP_PUSH_MM: begin
                    mem_raddr = ea;
                    r_d.hold  = mem_rdata;
                    r_d.busy  = 1'b1;
                    r_d.state = ST_COPY;
                end
                OP_POP: begin
                    r_d.done = 1'b1;
                    if (sp_top) begin
                        r_d.udf   = 1'b1;
                        r_d.rdata = '0;
                    end else begin
                        mem_raddr = sp_up;
                        r_d.rdata = mem_rdata;
                        r_d.sp    = sp_up;
                    end
                end
                default: begin
                    r_d.done = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.sp    <= SP_INIT;
            r_q.rdata <= '0;
            r_q.hold  <= '0;
            r_q.busy  <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.ovf   <= 1'b0;
            r_q.udf   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;
    assign busy_o  = r_q.busy;
    assign done_o  = r_q.done;
    assign sp_o    = r_q.sp;
    assign ovf_o   = r_q.ovf;
    assign udf_o   = r_q.udf;
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] op_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] sp_o,
    input logic       ovf_o,
    input logic       udf_o
);
    logic accept;
    assign accept = start_i && !busy_o;

    // R6: busy lasts one cycle and is followed by done
    p_busy_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o && !busy_o));

    // R4: input-byte push lowers pointer by one
    p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == 3'd3) |=> (sp_o == $past(sp_o) - 8'd1));

    // R8: pop on empty stack flags and keeps pointer
    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == 3'd5 && sp_o == 8'hFF) |=> (udf_o && done_o && sp_o == 8'hFF));

    // R5: overflow only with done and a wrapped pointer
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (done_o && sp_o == 8'hFF));

    // R3: loads and stores keep the pointer
    p_ldst_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_i == 3'd1 || op_i == 3'd2)) |=> $stable(sp_o));

    // R9: idle codes produce no done pulse
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7)) |=> (!done_o && $stable(sp_o)));

    // R7: pop on non-empty stack raises pointer by one
    p_pop_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == 3'd5 && sp_o != 8'hFF) |=> (sp_o == $past(sp_o) + 8'd1));
endmodule

bind shared_stack_mem ssm_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sp_o    (sp_o),
    .ovf_o   (ovf_o),
    .udf_o   (udf_o)
);

// File: tb/shared_stack_mem_tb.sv
module shared_stack_mem_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] base_i = 8'd0;
    logic [7:0] offset_i = 8'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       busy_o, done_o, ovf_o, udf_o;
    logic [7:0] sp_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shared_stack_mem u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (op_i),
        .base_i   (base_i),
        .offset_i (offset_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .sp_o     (sp_o),
        .ovf_o    (ovf_o),
        .udf_o    (udf_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // present one request for one edge, return at the following negedge
    task automatic issue(input logic go, input logic [2:0] op, input logic [7:0] b,
                         input logic [7:0] o, input logic [7:0] wd);
        @(negedge clk);
        start_i  = go;
        op_i     = op;
        base_i   = b;
        offset_i = o;
        wdata_i  = wd;
        @(negedge clk);
        start_i  = 1'b0;
        op_i     = 3'd0;
    endtask

    task automatic t_reset();
        chk("R1 sp", sp_o, 8'hFF);
        chk("R1 busy", {7'd0, busy_o}, 8'd0);
        chk("R1 done", {7'd0, done_o}, 8'd0);
        chk("R1 flags", {6'd0, ovf_o, udf_o}, 8'd0);
    endtask

    task automatic t_underflow();
        issue(1'b1, 3'd5, 8'd0, 8'd0, 8'd0);
        chk("R8 udf", {7'd0, udf_o}, 8'd1);
        chk("R8 done", {7'd0, done_o}, 8'd1);
        chk("R8 sp", sp_o, 8'hFF);
        chk("R8 rdata", rdata_o, 8'h00);
    endtask

    task automatic t_load_store();
        issue(1'b1, 3'd2, 8'h10, 8'h05, 8'hA5);
        chk("R3 sp after store", sp_o, 8'hFF);
        issue(1'b1, 3'd1, 8'h15, 8'h00, 8'h00);
        chk("R2 load 0x15", rdata_o, 8'hA5);
        chk("R2 done", {7'd0, done_o}, 8'd1);
        chk("R3 sp after load", sp_o, 8'hFF);
        issue(1'b1, 3'd2, 8'hF0, 8'h20, 8'h3C);
        issue(1'b1, 3'd1, 8'h08, 8'h08, 8'h00);
        chk("R2 wrap load 0x10", rdata_o, 8'h3C);
        issue(1'b1, 3'd1, 8'h00, 8'h15, 8'h00);
        chk("R2 offset only 0x15", rdata_o, 8'hA5);
    endtask

    task automatic t_idle();
        issue(1'b1, 3'd2, 8'hFF, 8'h00, 8'h11);
        issue(1'b0, 3'd3, 8'h00, 8'h00, 8'h99);
        chk("R9 start low done", {7'd0, done_o}, 8'd0);
        chk("R9 start low sp", sp_o, 8'hFF);
        issue(1'b1, 3'd0, 8'h00, 8'h00, 8'h99);
        chk("R9 op0 done", {7'd0, done_o}, 8'd0);
        issue(1'b1, 3'd6, 8'h00, 8'h00, 8'h99);
        chk("R9 op6 sp", sp_o, 8'hFF);
        issue(1'b1, 3'd7, 8'hFF, 8'h00, 8'h99);
        chk("R9 op7 done", {7'd0, done_o}, 8'd0);
        issue(1'b1, 3'd1, 8'hFF, 8'h00, 8'h00);
        chk("R9 mem 0xFF kept", rdata_o, 8'h11);
    endtask

    task automatic t_push_pop();
        issue(1'b1, 3'd3, 8'h00, 8'h00, 8'h01);
        chk("R4 sp after push", sp_o, 8'hFE);
        chk("R4 done", {7'd0, done_o}, 8'd1);
        issue(1'b1, 3'd3, 8'h00, 8'h00, 8'h02);
        issue(1'b1, 3'd3, 8'h00, 8'h00, 8'h03);
        chk("R4 sp after three", sp_o, 8'hFC);
        issue(1'b1, 3'd1, 8'hFF, 8'h00, 8'h00);
        chk("R4 mem 0xFF", rdata_o, 8'h01);
        issue(1'b1, 3'd1, 8'hFD, 8'h00, 8'h00);
        chk("R4 mem 0xFD", rdata_o, 8'h03);
        issue(1'b1, 3'd5, 8'h00, 8'h00, 8'h00);
        chk("R7 pop 1", rdata_o, 8'h03);
        chk("R7 sp 1", sp_o, 8'hFD);
        issue(1'b1, 3'd5, 8'h00, 8'h00, 8'h00);
        chk("R7 pop 2", rdata_o, 8'h02);
        issue(1'b1, 3'd5, 8'h00, 8'h00, 8'h00);
        chk("R7 pop 3", rdata_o, 8'h01);
        chk("R7 sp back", sp_o, 8'hFF);
        chk("R7 no udf", {7'd0, udf_o}, 8'd0);
    endtask

    task automatic t_push_mem();
        issue(1'b1, 3'd2, 8'h23, 8'h00, 8'h77);
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd4; base_i = 8'h20; offset_i = 8'h03; wdata_i = 8'h00;
        @(negedge clk);
        chk("R6 busy", {7'd0, busy_o}, 8'd1);
        chk("R6 no done yet", {7'd0, done_o}, 8'd0);
        chk("R6 sp held", sp_o, 8'hFF);
        op_i = 3'd3; wdata_i = 8'hEE;
        @(negedge clk);
        start_i = 1'b0; op_i = 3'd0;
        chk("R6 done", {7'd0, done_o}, 8'd1);
        chk("R6 busy low", {7'd0, busy_o}, 8'd0);
        chk("R6 sp", sp_o, 8'hFE);
        @(negedge clk);
        chk("R6 request ignored sp", sp_o, 8'hFE);
        issue(1'b1, 3'd5, 8'h00, 8'h00, 8'h00);
        chk("R6 copied byte", rdata_o, 8'h77);
        chk("R6 sp back", sp_o, 8'hFF);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 255; i++) begin
            issue(1'b1, 3'd3, 8'h00, 8'h00, 8'(i));
        end
        chk("R5 sp bottom", sp_o, 8'h00);
        chk("R5 no early ovf", {7'd0, ovf_o}, 8'd0);
        issue(1'b1, 3'd3, 8'h00, 8'h00, 8'h5A);
        chk("R5 ovf", {7'd0, ovf_o}, 8'd1);
        chk("R5 sp wrapped", sp_o, 8'hFF);
        chk("R5 done", {7'd0, done_o}, 8'd1);
        @(negedge clk);
        chk("R5 ovf one cycle", {7'd0, ovf_o}, 8'd0);
        issue(1'b1, 3'd1, 8'h00, 8'h00, 8'h00);
        chk("R5 mem 0x00", rdata_o, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_underflow();
        t_load_store();
        t_idle();
        t_push_pop();
        t_push_mem();
        t_overflow();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule